// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns 32-bit linear addresses into physical addresses. Each request carries an address, an access type (read or write) and a privilege (supervisor or user). When paging is enabled, the block consults a small fully associative translation cache. On a miss it walks a two-level table in memory. It first reads a directory word, located from a root frame number register, and then a table word. The two entries' rights are combined and checked against the request. Each response carries either the physical address or a page-fault flag with a three-bit cause.

Pages are 4 KiB, so the 32-bit space holds 2^20 pages. The linear address splits as follows:

- bits [31:22] select the directory word;
- bits [21:12] select the table word;
- bits [11:0] pass through as the page offset.

Every entry is one 32-bit word:

- bits [31:12] hold a frame number;
- bit 0 means present;
- bit 1 means writable;
- bit 2 means user-accessible.

Both request and response are valid/ready streams. A request is taken only when `req_ready` is high, which holds only while no walk or response is outstanding. A response holds its value until it is taken with `rsp_ready`. The memory request port holds its address until `mem_req_ready` is seen. The memory response carries no ready, so the walker always accepts it.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0 and the translation cache is empty.
- R2: With `paging_en` low at acceptance, the response comes the cycle after acceptance. It carries `rsp_addr` equal to the request address, `rsp_fault` 0 and `rsp_cause` 0, and the block makes no memory read.
- R3: On a cache miss the block makes exactly two reads. The first is the directory word at {root[19:0], va[31:22], 2'b00}. The second is the table word at {dir_entry[31:12], va[21:12], 2'b00}. The response address is {table_entry[31:12], va[11:0]}.
- R4: If either entry has bit 0 clear, the response has `rsp_fault`=1, `rsp_addr`=va and `rsp_cause[0]`=0. A clear directory entry ends the walk after one read. A translation that ends this way is not cached.
- R5: A write faults when bit 1 is clear in either entry. A user access faults when bit 2 is clear in either entry. Such a fault has `rsp_cause[0]`=1. In every fault, `rsp_cause[1]` equals the request's write flag and `rsp_cause[2]` equals its user flag. A response without a fault has `rsp_cause` 0.
- R6: A request whose page is cached is answered in the cycle after acceptance with no memory read. The same combined rights are applied, so a permission fault can come from the cache.
- R7: The cache holds 4 pages, including pages that returned a permission fault. It replaces them in fill order, starting from slot 0 after reset or flush. Once it is full, the next new page evicts the oldest fill.
- R8: A pulse on `flush` or on `root_we` empties the cache. A flush during a walk stops that walk's result from being cached. `root_we` loads the root frame used by walks accepted afterwards.
- R9: While `rsp_valid` is high and `rsp_ready` low, the response stays unchanged and `req_ready` stays 0. While `mem_req_valid` is high and `mem_req_ready` low, `mem_req_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Translation enable; when low, addresses pass through |
| root_we | input | 1 | Load root frame register and flush cache |
| root_frame | input | 20 | Frame number of the page directory |
| flush | input | 1 | Empty the translation cache |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made at user privilege |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_addr | output | 32 | Physical address, or the linear address on a fault |
| rsp_fault | output | 1 | Page fault |
| rsp_cause | output | 3 | {user, write, present} fault cause |
| mem_req_valid | output | 1 | Memory word read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 32 | Word-aligned byte address to read |
| mem_rsp_valid | input | 1 | Read data valid, one pulse per read |
| mem_rsp_data | input | 32 | Read data |

## Verification
The assertions assume three things about the memory port. It returns exactly one `mem_rsp_valid` pulse for each accepted read. It returns that pulse only after the read was taken. It never returns a pulse while no read is outstanding. The assertions also assume that request fields stay stable only at the cycle of acceptance. The bench memory meets these assumptions: it answers each read with one pulse two cycles after it is accepted, and it toggles `mem_req_ready` every cycle to exercise the hold rule. It drives requests only at falling edges, it holds `rsp_ready` low only in the back-pressure scenario, and it pulses `flush` mid-walk only while a walk is known to be in flight.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned VPN_W   = ADDR_W - OFF_W;
  localparam int unsigned CAUSE_W = 3;

  // entry bit positions
  localparam int unsigned ENT_P = 0;
  localparam int unsigned ENT_W = 1;
  localparam int unsigned ENT_U = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_REQ,
    ST_DIR_WAIT,
    ST_TBL_REQ,
    ST_TBL_WAIT,
    ST_RESP
  } walk_state_e;
endpackage

// File: rtl/pt_tlb.sv
module pt_tlb #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_w,
  output logic             lk_u,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_w,
  input  logic             fill_u
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  typedef struct packed {
    logic             v;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
    logic             w;
    logic             u;
  } slot_t;

  slot_t              slot_q [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [PTR_W-1:0]   ptr_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match[g] = slot_q[g].v && (slot_q[g].vpn == lk_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        slot_q[g] <= '0;
      end else if (fill_en && (ptr_q == PTR_W'(g))) begin
        slot_q[g] <= '{v: 1'b1, vpn: fill_vpn, ppn: fill_ppn, w: fill_w, u: fill_u};
      end
    end
  end

  always_comb begin
    lk_hit = |match;
    lk_ppn = '0;
    lk_w   = 1'b0;
    lk_u   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        lk_ppn = lk_ppn | slot_q[i].ppn;
        lk_w   = lk_w | slot_q[i].w;
        lk_u   = lk_u | slot_q[i].u;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ptr_q <= '0;
    end else if (fill_en) begin
      ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/pt_fault_eval.sv
module pt_fault_eval
  import pt_walker_pkg::*;
(
  input  logic               present,
  input  logic               w_ok,
  input  logic               u_ok,
  input  logic               is_wr,
  input  logic               is_usr,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  always_comb begin
    fault = !present || (is_wr && !w_ok) || (is_usr && !u_ok);
    cause = fault ? {is_usr, is_wr, present} : '0;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned TLB_ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               paging_en,
  input  logic               root_we,
  input  logic [VPN_W-1:0]   root_frame,
  input  logic               flush,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_vaddr,
  input  logic               req_write,
  input  logic               req_user,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic               rsp_fault,
  output logic [CAUSE_W-1:0] rsp_cause,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rsp_data
);
  walk_state_e        state_q;
  logic [ADDR_W-1:0]  va_q;
  logic               wr_q, usr_q, stale_q;
  logic [VPN_W-1:0]   base_q, root_q, tframe_q;
  logic               dw_q, du_q;
  logic [ADDR_W-1:0]  rsp_addr_q;
  logic               rsp_fault_q;
  logic [CAUSE_W-1:0] rsp_cause_q;

  logic               accept, tlb_flush, fill_en;
  logic               hit, hit_w, hit_u;
  logic [VPN_W-1:0]   hit_ppn;
  logic               ev_present, ev_w, ev_u, ev_wr, ev_usr, ev_fault;
  logic [CAUSE_W-1:0] ev_cause;
  logic               ent_p, ent_w, ent_u;
  logic               unused_data;

  assign ent_p       = mem_rsp_data[ENT_P];
  assign ent_w       = mem_rsp_data[ENT_W];
  assign ent_u       = mem_rsp_data[ENT_U];
  assign unused_data = ^mem_rsp_data[OFF_W-1:ENT_U+1];

  assign req_ready     = (state_q == ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign tlb_flush     = flush || root_we;
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_addr      = rsp_addr_q;
  assign rsp_fault     = rsp_fault_q;
  assign rsp_cause     = rsp_cause_q;
  assign mem_req_valid = (state_q == ST_DIR_REQ) || (state_q == ST_TBL_REQ);
  assign mem_req_addr  = (state_q == ST_DIR_REQ)
                         ? {root_q, va_q[ADDR_W-1 -: IDX_W], 2'b00}
                         : {tframe_q, va_q[OFF_W+IDX_W-1 -: IDX_W], 2'b00};
  assign fill_en       = (state_q == ST_TBL_WAIT) && mem_rsp_valid && ent_p
                         && !stale_q && !tlb_flush;

  pt_tlb #(
    .ENTRIES (TLB_ENTRIES),
    .VPN_W   (VPN_W),
    .PPN_W   (VPN_W)
  ) u_tlb (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (tlb_flush),
    .lk_vpn   (req_vaddr[ADDR_W-1:OFF_W]),
    .lk_hit   (hit),
    .lk_ppn   (hit_ppn),
    .lk_w     (hit_w),
    .lk_u     (hit_u),
    .fill_en  (fill_en),
    .fill_vpn (va_q[ADDR_W-1:OFF_W]),
    .fill_ppn (mem_rsp_data[ADDR_W-1:OFF_W]),
    .fill_w   (dw_q && ent_w),
    .fill_u   (du_q && ent_u)
  );

  // One checker shared by cache hits, directory and table responses
  always_comb begin
    unique case (state_q)
      ST_IDLE: begin
        ev_present = 1'b1;  ev_w = hit_w;  ev_u = hit_u;
        ev_wr = req_write;  ev_usr = req_user;
      end
      ST_DIR_WAIT: begin
        ev_present = ent_p;  ev_w = 1'b1;  ev_u = 1'b1;
        ev_wr = wr_q;        ev_usr = usr_q;
      end
      default: begin
        ev_present = ent_p;  ev_w = dw_q && ent_w;  ev_u = du_q && ent_u;
        ev_wr = wr_q;        ev_usr = usr_q;
      end
    endcase
  end

  pt_fault_eval u_eval (
    .present (ev_present),
    .w_ok    (ev_w),
    .u_ok    (ev_u),
    .is_wr   (ev_wr),
    .is_usr  (ev_usr),
    .fault   (ev_fault),
    .cause   (ev_cause)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      stale_q     <= 1'b0;
      base_q      <= '0;
      root_q      <= '0;
      tframe_q    <= '0;
      dw_q        <= 1'b0;
      du_q        <= 1'b0;
      rsp_addr_q  <= '0;
      rsp_fault_q <= 1'b0;
      rsp_cause_q <= '0;
    end else begin
      if (root_we) base_q <= root_frame;
      if (state_q != ST_IDLE && tlb_flush) stale_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: if (accept) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          usr_q   <= req_user;
          root_q  <= root_we ? root_frame : base_q;
          stale_q <= tlb_flush;
          if (!paging_en) begin
            rsp_addr_q  <= req_vaddr;
            rsp_fault_q <= 1'b0;
            rsp_cause_q <= '0;
            state_q     <= ST_RESP;
          end else if (hit) begin
            rsp_addr_q  <= ev_fault ? req_vaddr : {hit_ppn, req_vaddr[OFF_W-1:0]};
            rsp_fault_q <= ev_fault;
            rsp_cause_q <= ev_cause;
            state_q     <= ST_RESP;
          end else begin
            state_q <= ST_DIR_REQ;
          end
        end
        ST_DIR_REQ: if (mem_req_ready) state_q <= ST_DIR_WAIT;
        ST_DIR_WAIT: if (mem_rsp_valid) begin
          if (ev_fault) begin
            rsp_addr_q  <= va_q;
            rsp_fault_q <= 1'b1;
            rsp_cause_q <= ev_cause;
            state_q     <= ST_RESP;
          end else begin
            tframe_q <= mem_rsp_data[ADDR_W-1:OFF_W];
            dw_q     <= ent_w;
            du_q     <= ent_u;
            state_q  <= ST_TBL_REQ;
          end
        end
        ST_TBL_REQ: if (mem_req_ready) state_q <= ST_TBL_WAIT;
        ST_TBL_WAIT: if (mem_rsp_valid) begin
          rsp_addr_q  <= ev_fault ? va_q : {mem_rsp_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
          rsp_fault_q <= ev_fault;
          rsp_cause_q <= ev_cause;
          state_q     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        paging_en,
  input logic        root_we,
  input logic [19:0] root_frame,
  input logic        flush,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic        req_write,
  input logic        req_user,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_addr,
  input logic        rsp_fault,
  input logic [2:0]  rsp_cause,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic [31:0] mem_rsp_data
);
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr)
                                && $stable(rsp_fault) && $stable(rsp_cause));

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !paging_en |=> rsp_valid && !rsp_fault
                                             && rsp_addr == $past(req_vaddr));

  assert_ok_cause_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_cause == 3'b000);

  assert_idle_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);
endmodule

bind pt_walker pt_walker_chk u_chk (.*);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        paging_en = 1'b1;
  logic        root_we = 1'b0;
  logic [19:0] root_frame = '0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic        rsp_fault;
  logic [2:0]  rsp_cause;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  pt_walker dut (.*);

  // memory model: 16 KiB, one response pulse two cycles after each accepted read
  logic [31:0] mem [4096];
  int          nreads = 0;
  int          dly = 0;
  logic [31:0] pend_addr = '0, rd_last = '0, rd_prev = '0;

  always @(posedge clk) begin
    mem_req_ready <= ~mem_req_ready;
    mem_rsp_valid <= 1'b0;
    if (dly > 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[pend_addr[13:2]];
      end
    end
    if (mem_req_valid && mem_req_ready) begin
      pend_addr <= mem_req_addr;
      dly       <= 2;
      nreads    <= nreads + 1;
      rd_prev   <= rd_last;
      rd_last   <= mem_req_addr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_flush();
    @(negedge clk) flush = 1'b1;
    @(negedge clk) flush = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] va, input logic wr, input logic usr,
                       input logic ef, input logic [31:0] ea, input logic [2:0] ec,
                       input int ereads, input int elat, input string tag);
    int r0, lat;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    r0 = nreads;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    chk(rsp_fault == ef, {tag, " fault"}, 32'(rsp_fault), 32'(ef));
    chk(rsp_addr == ea, {tag, " addr"}, rsp_addr, ea);
    chk(rsp_cause == ec, {tag, " cause"}, 32'(rsp_cause), 32'(ec));
    chk(nreads - r0 == ereads, {tag, " reads"}, 32'(nreads - r0), 32'(ereads));
    if (elat >= 0) chk(lat == elat, {tag, " latency"}, 32'(lat), 32'(elat));
  endtask

  function automatic logic [31:0] pg(input int k, input logic [11:0] off);
    return {20'h80000 + 20'(k), off};
  endfunction

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 0);
  endtask

  task automatic t_passthru();
    paging_en = 1'b0;
    xlate(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF, 3'b000, 0, 1, "R2 pass write");
    xlate(32'h0040_0010, 1'b0, 1'b1, 1'b0, 32'h0040_0010, 3'b000, 0, 1, "R2 pass unmapped");
    paging_en = 1'b1;
  endtask

  task automatic t_walk();
    pulse_flush();
    xlate(32'h0000_3ABC, 1'b0, 1'b1, 1'b0, pg(3, 12'hABC), 3'b000, 2, -1, "R3 walk");
    chk(rd_prev == 32'h0000_0000, "R3 dir read addr", rd_prev, 32'h0);
    chk(rd_last == 32'h0000_100C, "R3 table read addr", rd_last, 32'h100C);
    xlate(32'h0000_3123, 1'b1, 1'b0, 1'b0, pg(3, 12'h123), 3'b000, 0, 1, "R6 hit");
  endtask

  task automatic t_rr();
    pulse_flush();
    for (int k = 0; k < 4; k++)
      xlate({20'(k), 12'h010}, 1'b0, 1'b0, 1'b0, pg(k, 12'h010), 3'b000, 2, -1, "R7 fill");
    xlate(32'h0000_0010, 1'b0, 1'b0, 1'b0, pg(0, 12'h010), 3'b000, 0, 1, "R7 full hit");
    xlate(32'h0000_4010, 1'b0, 1'b0, 1'b0, pg(4, 12'h010), 3'b000, 2, -1, "R7 fifth page");
    xlate(32'h0000_1010, 1'b0, 1'b0, 1'b0, pg(1, 12'h010), 3'b000, 0, 1, "R7 second kept");
    xlate(32'h0000_0010, 1'b0, 1'b0, 1'b0, pg(0, 12'h010), 3'b000, 2, -1, "R7 oldest evicted");
    xlate(32'h0000_1010, 1'b0, 1'b0, 1'b0, pg(1, 12'h010), 3'b000, 2, -1, "R7 next evicted");
    xlate(32'h0000_3010, 1'b0, 1'b0, 1'b0, pg(3, 12'h010), 3'b000, 0, 1, "R7 third kept");
    pulse_flush();
    xlate(32'h0000_3010, 1'b0, 1'b0, 1'b0, pg(3, 12'h010), 3'b000, 2, -1, "R8 flush empties");
  endtask

  task automatic t_perm();
    pulse_flush();
    xlate(32'h0000_6004, 1'b0, 1'b0, 1'b0, pg(6, 12'h004), 3'b000, 2, -1, "R5 ro read");
    xlate(32'h0000_6004, 1'b1, 1'b0, 1'b1, 32'h0000_6004, 3'b011, 0, 1, "R5 R6 ro write hit");
    xlate(32'h0000_6008, 1'b1, 1'b1, 1'b1, 32'h0000_6008, 3'b111, 0, 1, "R5 ro user write");
    xlate(32'h0000_7000, 1'b0, 1'b1, 1'b1, 32'h0000_7000, 3'b101, 2, -1, "R5 user on sup page");
    xlate(32'h0000_7000, 1'b1, 1'b0, 1'b0, pg(7, 12'h000), 3'b000, 0, 1, "R7 fault page cached");
    xlate(32'h0080_0005, 1'b0, 1'b1, 1'b1, 32'h0080_0005, 3'b101, 2, -1, "R5 dir lacks user");
    xlate(32'h0080_0005, 1'b0, 1'b0, 1'b0, pg(0, 12'h005), 3'b000, 0, 1, "R5 dir sup ok");
  endtask

  task automatic t_notpresent();
    pulse_flush();
    xlate(32'h0000_8020, 1'b0, 1'b1, 1'b1, 32'h0000_8020, 3'b100, 2, -1, "R4 table absent");
    xlate(32'h0000_8020, 1'b0, 1'b1, 1'b1, 32'h0000_8020, 3'b100, 2, -1, "R4 absent not cached");
    xlate(32'h0040_0010, 1'b1, 1'b0, 1'b1, 32'h0040_0010, 3'b010, 1, -1, "R4 dir absent");
  endtask

  task automatic t_root();
    pulse_flush();
    xlate(32'h0000_0123, 1'b0, 1'b0, 1'b0, pg(0, 12'h123), 3'b000, 2, -1, "R8 old root");
    xlate(32'h0000_0123, 1'b0, 1'b0, 1'b0, pg(0, 12'h123), 3'b000, 0, 1, "R8 old root hit");
    @(negedge clk) begin root_frame = 20'h00002; root_we = 1'b1; end
    @(negedge clk) root_we = 1'b0;
    xlate(32'h0000_0123, 1'b0, 1'b0, 1'b0, 32'h9000_0123, 3'b000, 2, -1, "R8 new root");
    chk(rd_prev == 32'h0000_2000, "R8 new dir addr", rd_prev, 32'h2000);
    @(negedge clk) begin root_frame = 20'h00000; root_we = 1'b1; end
    @(negedge clk) root_we = 1'b0;
  endtask

  task automatic t_midwalk();
    pulse_flush();
    fork
      xlate(32'h0000_5000, 1'b0, 1'b0, 1'b0, pg(5, 12'h000), 3'b000, 2, -1, "R8 walk with flush");
      begin repeat (3) @(negedge clk); flush = 1'b1; @(negedge clk) flush = 1'b0; end
    join
    xlate(32'h0000_5000, 1'b0, 1'b0, 1'b0, pg(5, 12'h000), 3'b000, 2, -1, "R8 fill suppressed");
  endtask

  task automatic t_backpressure();
    logic [31:0] a0;
    pulse_flush();
    rsp_ready = 1'b0;
    @(negedge clk);
    req_vaddr = 32'h0000_2444; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    a0 = rsp_addr;
    chk(a0 == pg(2, 12'h444), "R9 held addr", a0, pg(2, 12'h444));
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_addr == a0, "R9 response stable", rsp_addr, a0);
      chk(req_ready == 1'b0, "R9 no accept while held", 32'(req_ready), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 released", 32'(rsp_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[0]     = 32'h0000_1007;            // dir 0 -> table frame 1
    mem[1]     = 32'h0000_0000;            // dir 1 absent
    mem[2]     = 32'h0000_1003;            // dir 2 -> table frame 1, supervisor only
    for (int k = 0; k < 6; k++) mem[12'h400 + k] = {20'h80000 + 20'(k), 12'h007};
    mem[12'h406] = {20'h80006, 12'h005};   // read-only, user
    mem[12'h407] = {20'h80007, 12'h003};   // supervisor only
    mem[12'h408] = {20'h80008, 12'h006};   // absent
    mem[12'h800] = 32'h0000_3007;          // second directory
    mem[12'hC00] = 32'h9000_0007;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_passthru();
    t_walk();
    t_rr();
    t_perm();
    t_notpresent();
    t_root();
    t_midwalk();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule